// File: doc/BRIEF.md
# Dual-Channel Converter Load Sequencer

This block turns write requests from a valid/ready handshake into correctly timed load cycles on the parallel input of a dual 8-bit converter. The two channel latches share one data bus. A steering line picks the latch that a cycle writes: low for channel A, high for channel B. A latch is transparent while the active-low chip select and the active-low write strobe are both low. It keeps the bus value present just before either of them rises.

Each request carries a code and a channel bit. The sequencer captures both at acceptance and drives the bus, steering line and chip select from registers. It then waits a programmable setup interval and pulses the registered strobe for a programmable width. After that it keeps chip select low for a programmable hold interval before it accepts the next request. All three intervals are counted in clock cycles and must each be at least 1. A shadow copy of the last code latched into each channel updates on the clock edge where the strobe rises. Another part of the design can compare these copies with the latch contents.

Top module: `dac_write_seq`

## Requirements
- R1: While reset is asserted and right after a synchronous reset, chip select and write strobe are high, ready is high, and both shadow codes are 0x00.
- R2: Ready is high in idle. It goes low on the clock edge that accepts a request (valid and ready both high). It stays low for exactly SETUP_CYC+PULSE_CYC+HOLD_CYC cycles.
- R3: Chip select falls on the accepting edge. The write strobe falls exactly SETUP_CYC cycles later.
- R4: The write strobe stays low for exactly PULSE_CYC cycles per request.
- R5: After the strobe rises, chip select stays low for exactly HOLD_CYC cycles and then rises. It is therefore still low on the strobe's rising edge.
- R6: The steering line is 0 for a channel bit of 0 (channel A) and 1 for a channel bit of 1 (channel B). Bus bit i equals code bit i, with bit 7 as the MSB. Both hold their captured values throughout the cycle, across the strobe's rising edge.
- R7: On the edge where the strobe rises, the shadow code of the written channel takes the request code. The other channel's shadow code keeps its value.
- R8: Changes to the request code and channel while ready is low have no effect on the bus, the steering line, the strobe timing or the shadow codes.
- R9: The write strobe is never low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_code | input | DATA_W | Code to load |
| req_chan | input | 1 | Target channel: 0 = A, 1 = B |
| bus_data | output | DATA_W | Shared converter data bus |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low, registered |
| bus_sel | output | 1 | Channel steering line: 0 = A, 1 = B |
| shadow_a | output | DATA_W | Last code latched into channel A |
| shadow_b | output | DATA_W | Last code latched into channel B |

## Verification
Writes alternate between the two channels with the codes 0xA5, 0x3C, 0xFF, 0x00, 0x01 and 0x80. An all-ones or all-zeros word and single bits at either end of the word show bit order and steering errors that a symmetric pattern would hide. Each write is traced cycle by cycle against the expected setup, pulse and hold boundaries, so an interval that is off by one cycle stands out. A behavioural transparent-latch model in the bench shows whether the right latch captured the right word and the other latch kept its value. While the sequencer is busy, the request inputs carry the inverted code and the opposite channel. Any leak of a new request into a cycle in flight then shows up on the bus or in the latch model.

// File: rtl/dws_pkg.sv
package dws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } seq_state_e;

    function automatic int unsigned max_of3(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/dws_interval_timer.sv
// Down counter: loaded with (interval - 1), reports expiry at zero.
module dws_interval_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/dws_shadow_bank.sv
// One shadow register per channel, written when the strobe rises.
module dws_shadow_bank #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NUM_CH = 2,
    localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [SEL_W-1:0]               wr_sel,
    input  logic [DATA_W-1:0]              wr_code,
    output logic [NUM_CH-1:0][DATA_W-1:0]  shadow
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        logic [DATA_W-1:0] code_d, code_q;

        always_comb begin
            code_d = code_q;
            if (wr_en && (wr_sel == SEL_W'(ch))) begin
                code_d = wr_code;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                code_q <= '0;
            end else begin
                code_q <= code_d;
            end
        end

        assign shadow[ch] = code_q;
    end

endmodule

// File: rtl/dac_write_seq.sv
// Load-cycle sequencer for a dual converter with one shared data port.
module dac_write_seq
    import dws_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned SETUP_CYC = 9,
    parameter int unsigned PULSE_CYC = 9,
    parameter int unsigned HOLD_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] req_code,
    input  logic              req_chan,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_cs_n,
    output logic              bus_wr_n,
    output logic              bus_sel,
    output logic [DATA_W-1:0] shadow_a,
    output logic [DATA_W-1:0] shadow_b
);

    localparam int unsigned MAX_CYC = max_of3(SETUP_CYC, PULSE_CYC, HOLD_CYC);
    localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);
    localparam int unsigned NUM_CH = 2;

    typedef struct packed {
        seq_state_e        st;
        logic [DATA_W-1:0] data;
        logic              sel;
        logic              cs_n;
        logic              wr_n;
    } seq_regs_t;

    localparam seq_regs_t REGS_RESET = '{
        st:   ST_IDLE,
        data: '0,
        sel:  1'b0,
        cs_n: 1'b1,
        wr_n: 1'b1
    };

    seq_regs_t r_d, r_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             shadow_we;
    logic [NUM_CH-1:0][DATA_W-1:0] shadow_all;

    dws_interval_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // Bus, steering and chip select only move at acceptance or at the end
    // of hold, both while the strobe is high.
    always_comb begin
        r_d       = r_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        shadow_we = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st   = ST_SETUP;
                    r_d.data = req_code;
                    r_d.sel  = req_chan;
                    r_d.cs_n = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = LD_SETUP;
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    r_d.st   = ST_STROBE;
                    r_d.wr_n = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = LD_PULSE;
                end
            end
            ST_STROBE: begin
                if (tmr_expired) begin
                    r_d.st    = ST_HOLD;
                    r_d.wr_n  = 1'b1;
                    shadow_we = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_HOLD;
                end
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    r_d.st   = ST_IDLE;
                    r_d.cs_n = 1'b1;
                end
            end
            default: begin
                r_d = REGS_RESET;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= REGS_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    dws_shadow_bank #(
        .DATA_W (DATA_W),
        .NUM_CH (NUM_CH)
    ) u_shadow (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (shadow_we),
        .wr_sel  (r_q.sel),
        .wr_code (r_q.data),
        .shadow  (shadow_all)
    );

    assign req_ready = (r_q.st == ST_IDLE);
    assign bus_data  = r_q.data;
    assign bus_sel   = r_q.sel;
    assign bus_cs_n  = r_q.cs_n;
    assign bus_wr_n  = r_q.wr_n;
    assign shadow_a  = shadow_all[0];
    assign shadow_b  = shadow_all[1];

endmodule

// File: rtl/dws_checker.sv
module dws_checker #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned PULSE_CYC = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_cs_n,
    input logic              bus_wr_n,
    input logic              bus_sel,
    input logic [DATA_W-1:0] shadow_a,
    input logic [DATA_W-1:0] shadow_b
);

    logic [15:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
        end else if (!bus_wr_n) begin
            low_cnt <= low_cnt + 16'd1;
        end else begin
            low_cnt <= '0;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (bus_cs_n && bus_wr_n && req_ready && shadow_a == '0 && shadow_b == '0));

    assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_cs_n |-> !req_ready);

    assert_accept_starts_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!bus_cs_n && bus_wr_n));

    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_wr_n) |-> (low_cnt == 16'(PULSE_CYC)));

    assert_cs_after_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_n |=> !bus_cs_n);

    assert_bus_stable_R6: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_n |=> ($stable(bus_data) && $stable(bus_sel)));

    assert_shadow_capture_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_wr_n) |-> ((bus_sel ? shadow_b : shadow_a) == bus_data));

    assert_shadow_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !$rose(bus_wr_n) |-> ($stable(shadow_a) && $stable(shadow_b)));

    assert_strobe_inside_cs_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_n |-> !bus_cs_n);

endmodule

bind dac_write_seq dws_checker #(
    .DATA_W    (DATA_W),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .bus_data  (bus_data),
    .bus_cs_n  (bus_cs_n),
    .bus_wr_n  (bus_wr_n),
    .bus_sel   (bus_sel),
    .shadow_a  (shadow_a),
    .shadow_b  (shadow_b)
);

// File: tb/dac_write_seq_tb.sv
module dac_write_seq_tb;

    localparam int S   = 4;
    localparam int P   = 3;
    localparam int H   = 2;
    localparam int TOT = S + P + H;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [7:0] req_code = 8'h00;
    logic       req_chan = 1'b0;
    logic [7:0] bus_data;
    logic       bus_cs_n, bus_wr_n, bus_sel;
    logic [7:0] shadow_a, shadow_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] mdl_a = 8'h00;
    logic [7:0] mdl_b = 8'h00;

    always #5 clk = ~clk;

    dac_write_seq #(
        .DATA_W    (8),
        .SETUP_CYC (S),
        .PULSE_CYC (P),
        .HOLD_CYC  (H)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_code  (req_code),
        .req_chan  (req_chan),
        .bus_data  (bus_data),
        .bus_cs_n  (bus_cs_n),
        .bus_wr_n  (bus_wr_n),
        .bus_sel   (bus_sel),
        .shadow_a  (shadow_a),
        .shadow_b  (shadow_b)
    );

    // Behavioural transparent latches of the converter.
    always @(bus_cs_n or bus_wr_n or bus_sel or bus_data) begin
        if (!bus_cs_n && !bus_wr_n) begin
            if (bus_sel) mdl_b = bus_data;
            else         mdl_a = bus_data;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 cs_n in reset", 32'(bus_cs_n), 32'd1);
        check("R1 wr_n in reset", 32'(bus_wr_n), 32'd1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 cs_n after reset", 32'(bus_cs_n), 32'd1);
        check("R1 wr_n after reset", 32'(bus_wr_n), 32'd1);
        check("R1 ready after reset", 32'(req_ready), 32'd1);
        check("R1 shadow_a after reset", 32'(shadow_a), 32'h00);
        check("R1 shadow_b after reset", 32'(shadow_b), 32'h00);
    endtask

    task automatic t_write(input logic [7:0] code, input logic chan);
        logic [7:0] own_before, other_before, mdl_other_before, own_now, other_now;
        int cs_bad = 0, wr_bad = 0, rdy_bad = 0, bus_bad = 0, sh_bad = 0;
        own_before       = chan ? shadow_b : shadow_a;
        other_before     = chan ? shadow_a : shadow_b;
        mdl_other_before = chan ? mdl_a : mdl_b;
        @(negedge clk);
        check("R2 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_code  = code;
        req_chan  = chan;
        @(negedge clk);
        // R8: conflicting request content while busy
        req_code = ~code;
        req_chan = ~chan;
        for (int k = 1; k <= TOT + 1; k++) begin
            if (k > 1) @(negedge clk);
            if (k == TOT + 1) req_valid = 1'b0;
            if (bus_cs_n !== (k > TOT)) cs_bad++;
            if (bus_wr_n !== !(k > S && k <= S + P)) wr_bad++;
            if (req_ready !== (k > TOT)) rdy_bad++;
            if (k <= TOT && (bus_data !== code || bus_sel !== chan)) bus_bad++;
            own_now   = chan ? shadow_b : shadow_a;
            other_now = chan ? shadow_a : shadow_b;
            if (other_now !== other_before) sh_bad++;
            if (k <= S + P && own_now !== own_before) sh_bad++;
            if (k > S + P && own_now !== code) sh_bad++;
        end
        check("R3/R5 chip select window mismatches", 32'(cs_bad), 32'd0);
        check("R3/R4 strobe window mismatches", 32'(wr_bad), 32'd0);
        check("R2 ready window mismatches", 32'(rdy_bad), 32'd0);
        check("R6/R8 bus and steering mismatches", 32'(bus_bad), 32'd0);
        check("R7 shadow timing mismatches", 32'(sh_bad), 32'd0);
        check("R6 latch of target channel", 32'(chan ? mdl_b : mdl_a), 32'(code));
        check("R8 latch of other channel", 32'(chan ? mdl_a : mdl_b), 32'(mdl_other_before));
        check("R9 latch vs shadow", 32'(chan ? shadow_b : shadow_a), 32'(chan ? mdl_b : mdl_a));
    endtask

    initial begin
        t_reset();
        t_write(8'hA5, 1'b0);
        t_write(8'h3C, 1'b1);
        t_write(8'hFF, 1'b0);
        t_write(8'h00, 1'b1);
        t_write(8'h01, 1'b0);
        t_write(8'h80, 1'b1);
        @(negedge clk);
        check("R7 final shadow_a", 32'(shadow_a), 32'h01);
        check("R7 final shadow_b", 32'(shadow_b), 32'h80);
        check("R9 idle cs_n", 32'(bus_cs_n), 32'd1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule